// File: doc/BRIEF.md
# Display Address Counter with Auto-Increment

This block keeps the write pointers of a dot-matrix display controller for three memory targets: the full-dot bitmap memory, the character code map and the user-defined glyph RAM. The host loads the pointer fields through address-register loads. It then streams data writes. After each write, the block moves the pointer of the target that was written. The move follows a 2-bit increment mode taken from the controller's control register.

Each target has its own range rules. Bitmap columns count 00H..0EH and rows count 00H..48H. Character columns wrap once they pass the last visible column, 13H. The glyph RAM pointer always advances along glyph lines, whatever the mode asks. It passes through a spare eighth line slot, and a write there is thrown away. The block drives the glyph RAM write enable and masks the write data, so a dummy write cannot reach the array.

Top module: `dsp_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pointer field (`fd_x`, `fd_y`, `ch_x`, `ch_y`, `ug_addr`) becomes 0.
- R2: In mode 00, a bitmap write (target 0) raises `fd_x` by one. From 0EH or above it returns to 00H, and `fd_y` advances at the same time. `fd_y` goes from 48H or above to 00H.
- R3: In mode 01, a bitmap write raises `fd_y` by one and leaves `fd_x` unchanged. From 48H or above, `fd_y` returns to 00H.
- R4: In mode 00, a character write (target 1) raises `ch_x` by one. From 13H or above (this includes the off-screen columns 14H..15H), `ch_x` returns to 00H and `ch_y` advances modulo 8.
- R5: In mode 01, a character write raises `ch_y` by one, going from 07H back to 00H, and leaves `ch_x` unchanged.
- R6: In mode 10 or 11, no write changes any pointer.
- R7: `ug_addr` is {glyph code[6:3], line[2:0]}. In mode 00 and in mode 01, a glyph write (target 2) raises the line by one. Line 6 goes to line 7. Line 7 goes to line 0, and the code advances, with code 15 going to 0.
- R8: `ug_we` is high exactly when a glyph write is strobed and the current line is 0..6. `ug_wdata` carries `wr_data[4:0]`.
- R9: Load codes are 0 = bitmap column, 1 = bitmap row, 2 = character column, 3 = character row, 4 = glyph address. A loaded field takes the low bits of `ld_val`. When a load hits any field of the target that is being written in the same cycle, that write's step is dropped for that target.
- R10: A write with target 3, and a load with codes 5..7, change nothing.
- R11: A write moves only the pointer of the target it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Address-field load strobe |
| ld_reg | input | 3 | Field select for the load (codes in R9) |
| ld_val | input | 8 | Load value; low bits are used |
| wr_en | input | 1 | Data write strobe |
| wr_tgt | input | 2 | Written target: 0 bitmap, 1 character, 2 glyph, 3 none |
| wr_data | input | 8 | Write data for the glyph RAM |
| inc_mode | input | 2 | 00 column step, 01 row step, 1x hold |
| fd_x | output | 4 | Bitmap byte column |
| fd_y | output | 7 | Bitmap row |
| ch_x | output | 5 | Character column |
| ch_y | output | 3 | Character row |
| ug_addr | output | 7 | Glyph RAM address {code, line} |
| ug_we | output | 1 | Glyph RAM write enable, low in the spare slot |
| ug_wdata | output | 5 | Glyph RAM write data |

## Verification
A field load and a data write can arrive in the same cycle, and this case needs its own tests. The bench provokes it twice. In one case the load targets the pointer that the write would step, and the expected result is the loaded value with no step on top. In the other case the load goes to a different target, and the expected result is that the written target still steps while the loaded field takes its new value. Each outcome is judged on the pointer ports at the next falling edge.

// File: rtl/dsp_addr_pkg.sv
// Shared codes for the display address counter.
// Assumes: the load and target codes below are fixed by the host-side decoder.
package dsp_addr_pkg;
    localparam logic [2:0] LD_FDX = 3'd0;
    localparam logic [2:0] LD_FDY = 3'd1;
    localparam logic [2:0] LD_CHX = 3'd2;
    localparam logic [2:0] LD_CHY = 3'd3;
    localparam logic [2:0] LD_UGA = 3'd4;

    localparam logic [1:0] TGT_FD   = 2'd0;
    localparam logic [1:0] TGT_CH   = 2'd1;
    localparam logic [1:0] TGT_UG   = 2'd2;

    localparam logic [1:0] MODE_COL = 2'b00;
    localparam logic [1:0] MODE_ROW = 2'b01;
endpackage

// File: rtl/dsp_wrap_step.sv
// Next value of a wrapping up-counter field.
// Assumes: LAST fits in W bits; any value at or above LAST wraps to zero.
module dsp_wrap_step #(
    parameter int W    = 4,
    parameter int LAST = 14
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    // Wrap detection and increment.
    always_comb begin
        wrap = (cur >= W'(LAST));
        nxt  = wrap ? '0 : cur + 1'b1;
    end
endmodule

// File: rtl/dsp_xy_addr.sv
// Two-field pointer (X minor, Y major) with load and step.
// Assumes: a load of either field cancels a step in the same cycle;
// step_x carries into Y on X wrap, step_y moves Y alone.
module dsp_xy_addr #(
    parameter int X_LAST = 14,
    parameter int Y_LAST = 72,
    parameter int XW     = $clog2(X_LAST + 1),
    parameter int YW     = $clog2(Y_LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_x,
    input  logic          ld_y,
    input  logic [XW-1:0] ld_x_val,
    input  logic [YW-1:0] ld_y_val,
    input  logic          wr,
    input  logic          step_x,
    input  logic          step_y,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);
    logic [XW-1:0] x_nxt;
    logic [YW-1:0] y_nxt;
    logic          x_wrap;
    logic          y_wrap;

    dsp_wrap_step #(.W(XW), .LAST(X_LAST)) u_xs (.cur(x), .nxt(x_nxt), .wrap(x_wrap));
    dsp_wrap_step #(.W(YW), .LAST(Y_LAST)) u_ys (.cur(y), .nxt(y_nxt), .wrap(y_wrap));

    // Pointer register: reset, load priority, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (ld_x || ld_y) begin
            if (ld_x) x <= ld_x_val;
            if (ld_y) y <= ld_y_val;
        end else if (wr) begin
            if (step_x) begin
                x <= x_nxt;
                if (x_wrap) y <= y_nxt;
            end else if (step_y) begin
                y <= y_nxt;
            end
        end
    end
endmodule

// File: rtl/dsp_addr_seq.sv
// Display address counter: bitmap, character-map and glyph-RAM write pointers.
// Assumes: one write and one load per cycle at most; pointers are registered
// and move on the clock edge that samples the strobe.
module dsp_addr_seq
    import dsp_addr_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int FD_X_LAST    = 14,
    parameter int FD_Y_LAST    = 72,
    parameter int CH_X_WRAP    = 19,
    parameter int CH_Y_LAST    = 7,
    parameter int UG_LINES     = 7,
    parameter int UG_CODE_LAST = 15,
    parameter int UG_DATA_W    = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ld_en,
    input  logic [2:0]                             ld_reg,
    input  logic [DATA_W-1:0]                      ld_val,
    input  logic                                   wr_en,
    input  logic [1:0]                             wr_tgt,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic [1:0]                             inc_mode,
    output logic [$clog2(FD_X_LAST+1)-1:0]         fd_x,
    output logic [$clog2(FD_Y_LAST+1)-1:0]         fd_y,
    output logic [$clog2(CH_X_WRAP+3)-1:0]         ch_x,
    output logic [$clog2(CH_Y_LAST+1)-1:0]         ch_y,
    output logic [$clog2(UG_LINES+1)+$clog2(UG_CODE_LAST+1)-1:0] ug_addr,
    output logic                                   ug_we,
    output logic [UG_DATA_W-1:0]                   ug_wdata
);
    localparam int FXW = $clog2(FD_X_LAST + 1);
    localparam int FYW = $clog2(FD_Y_LAST + 1);
    localparam int CXW = $clog2(CH_X_WRAP + 3);
    localparam int CYW = $clog2(CH_Y_LAST + 1);
    localparam int ULW = $clog2(UG_LINES + 1);
    localparam int UCW = $clog2(UG_CODE_LAST + 1);

    logic          col_mode;
    logic          row_mode;
    logic          wr_fd;
    logic          wr_ch;
    logic          wr_ug;
    logic [ULW-1:0] ug_line;
    logic [UCW-1:0] ug_code;

    // Mode and target decode.
    always_comb begin
        col_mode = (inc_mode == MODE_COL);
        row_mode = (inc_mode == MODE_ROW);
        wr_fd    = wr_en && (wr_tgt == TGT_FD);
        wr_ch    = wr_en && (wr_tgt == TGT_CH);
        wr_ug    = wr_en && (wr_tgt == TGT_UG);
    end

    dsp_xy_addr #(.X_LAST(FD_X_LAST), .Y_LAST(FD_Y_LAST), .XW(FXW), .YW(FYW)) u_fd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_x     (ld_en && (ld_reg == LD_FDX)),
        .ld_y     (ld_en && (ld_reg == LD_FDY)),
        .ld_x_val (ld_val[FXW-1:0]),
        .ld_y_val (ld_val[FYW-1:0]),
        .wr       (wr_fd),
        .step_x   (col_mode),
        .step_y   (row_mode),
        .x        (fd_x),
        .y        (fd_y)
    );

    dsp_xy_addr #(.X_LAST(CH_X_WRAP), .Y_LAST(CH_Y_LAST), .XW(CXW), .YW(CYW)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_x     (ld_en && (ld_reg == LD_CHX)),
        .ld_y     (ld_en && (ld_reg == LD_CHY)),
        .ld_x_val (ld_val[CXW-1:0]),
        .ld_y_val (ld_val[CYW-1:0]),
        .wr       (wr_ch),
        .step_x   (col_mode),
        .step_y   (row_mode),
        .x        (ch_x),
        .y        (ch_y)
    );

    // Glyph pointer: line is the minor field, code the major; both
    // auto-increment modes step the line, the spare slot is LAST.
    dsp_xy_addr #(.X_LAST(UG_LINES), .Y_LAST(UG_CODE_LAST), .XW(ULW), .YW(UCW)) u_ug (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_x     (ld_en && (ld_reg == LD_UGA)),
        .ld_y     (ld_en && (ld_reg == LD_UGA)),
        .ld_x_val (ld_val[ULW-1:0]),
        .ld_y_val (ld_val[ULW+UCW-1:ULW]),
        .wr       (wr_ug),
        .step_x   (!inc_mode[1]),
        .step_y   (1'b0),
        .x        (ug_line),
        .y        (ug_code)
    );

    // Glyph RAM write port: suppressed in the spare line slot.
    always_comb begin
        ug_addr  = {ug_code, ug_line};
        ug_we    = wr_ug && (ug_line < ULW'(UG_LINES));
        ug_wdata = wr_data[UG_DATA_W-1:0];
    end

    wire unused_bits = &{1'b0, wr_data[DATA_W-1:UG_DATA_W], ld_val[DATA_W-1:ULW+UCW]};
endmodule

// File: rtl/dsp_addr_seq_chk.sv
// Property checker for dsp_addr_seq, attached by bind.
// Assumes: default parameter codes from dsp_addr_pkg.
module dsp_addr_seq_chk
    import dsp_addr_pkg::*;
#(
    parameter int FXW = 4, parameter int FYW = 7, parameter int CXW = 5,
    parameter int CYW = 3, parameter int ULW = 3, parameter int UCW = 4,
    parameter int FD_X_LAST = 14, parameter int FD_Y_LAST = 72,
    parameter int CH_X_WRAP = 19, parameter int UG_LINES = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ld_en,
    input logic [2:0]           ld_reg,
    input logic [FXW-1:0]       ld_fdx,
    input logic                 wr_en,
    input logic [1:0]           wr_tgt,
    input logic [1:0]           inc_mode,
    input logic [FXW-1:0]       fd_x,
    input logic [FYW-1:0]       fd_y,
    input logic [CXW-1:0]       ch_x,
    input logic [CYW-1:0]       ch_y,
    input logic [ULW+UCW-1:0]   ug_addr
);
    logic ld_fd, ld_ch, ld_ug;
    // Per-target load detection.
    always_comb begin
        ld_fd = ld_en && (ld_reg == LD_FDX || ld_reg == LD_FDY);
        ld_ch = ld_en && (ld_reg == LD_CHX || ld_reg == LD_CHY);
        ld_ug = ld_en && (ld_reg == LD_UGA);
    end

    assert_fd_xwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_FD && inc_mode == MODE_COL && !ld_fd && fd_x >= FXW'(FD_X_LAST))
        |=> fd_x == '0);

    assert_fd_rowstep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_FD && inc_mode == MODE_ROW && !ld_fd && fd_y < FYW'(FD_Y_LAST))
        |=> (fd_y == FYW'($past(fd_y) + 1'b1)) && $stable(fd_x));

    assert_ch_xwrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_CH && inc_mode == MODE_COL && !ld_ch && ch_x >= CXW'(CH_X_WRAP))
        |=> ch_x == '0);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && inc_mode[1] && !ld_en)
        |=> $stable(fd_x) && $stable(fd_y) && $stable(ch_x) && $stable(ch_y) && $stable(ug_addr));

    assert_ug_spare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_UG && !inc_mode[1] && !ld_ug && ug_addr[ULW-1:0] == ULW'(UG_LINES - 1))
        |=> ug_addr[ULW-1:0] == ULW'(UG_LINES));

    assert_ug_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_UG && !inc_mode[1] && !ld_ug && ug_addr[ULW-1:0] == ULW'(UG_LINES))
        |=> (ug_addr[ULW-1:0] == '0) && (ug_addr[ULW+UCW-1:ULW] == UCW'($past(ug_addr[ULW+UCW-1:ULW]) + 1'b1)));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_reg == LD_FDX) |=> fd_x == $past(ld_fdx));
endmodule

bind dsp_addr_seq dsp_addr_seq_chk #(
    .FXW(FXW), .FYW(FYW), .CXW(CXW), .CYW(CYW), .ULW(ULW), .UCW(UCW),
    .FD_X_LAST(FD_X_LAST), .FD_Y_LAST(FD_Y_LAST), .CH_X_WRAP(CH_X_WRAP), .UG_LINES(UG_LINES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_reg(ld_reg), .ld_fdx(ld_val[FXW-1:0]),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .inc_mode(inc_mode),
    .fd_x(fd_x), .fd_y(fd_y), .ch_x(ch_x), .ch_y(ch_y), .ug_addr(ug_addr)
);

// File: tb/dsp_addr_seq_tb_top.sv
// Self-checking bench for dsp_addr_seq: vector table, then directed tests.
module dsp_addr_seq_tb_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic       ld;
        logic [2:0] lreg;
        logic [7:0] lval;
        logic       wr;
        logic [1:0] tgt;
        logic [1:0] mode;
        logic [3:0] fx;
        logic [6:0] fy;
        logic [4:0] cx;
        logic [2:0] cy;
        logic [6:0] ug;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    // Fields: ld, lreg, lval, wr, tgt, mode | expected fx, fy, cx, cy, ug | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'h0D, 1'b0, 2'd0, 2'b00, 4'hD, 7'd0,  5'd0,  3'd0, 7'h00, 4'd9 },  // R9 load
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b00, 4'hE, 7'd0,  5'd0,  3'd0, 7'h00, 4'd2 },  // R2
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b00, 4'h0, 7'd1,  5'd0,  3'd0, 7'h00, 4'd2 },  // R2 wrap
        '{1'b1, 3'd1, 8'd72, 1'b0, 2'd0, 2'b00, 4'h0, 7'd72, 5'd0,  3'd0, 7'h00, 4'd9 },
        '{1'b1, 3'd0, 8'h0E, 1'b0, 2'd0, 2'b00, 4'hE, 7'd72, 5'd0,  3'd0, 7'h00, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd2 },  // R2 both wrap
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b01, 4'h0, 7'd1,  5'd0,  3'd0, 7'h00, 4'd3 },  // R3
        '{1'b1, 3'd1, 8'd72, 1'b0, 2'd0, 2'b00, 4'h0, 7'd72, 5'd0,  3'd0, 7'h00, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b01, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd3 },  // R3 wrap
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 2'b10, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd6 },  // R6
        '{1'b1, 3'd2, 8'd18, 1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd18, 3'd0, 7'h00, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b00, 4'h0, 7'd0,  5'd19, 3'd0, 7'h00, 4'd4 },  // R4
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b00, 4'h0, 7'd0,  5'd0,  3'd1, 7'h00, 4'd4 },  // R4 wrap at 13H
        '{1'b1, 3'd3, 8'd7,  1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd0,  3'd7, 7'h00, 4'd9 },
        '{1'b1, 3'd2, 8'd21, 1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd21, 3'd7, 7'h00, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd4 },  // R4 from 15H
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b01, 4'h0, 7'd0,  5'd0,  3'd1, 7'h00, 4'd5 },  // R5
        '{1'b1, 3'd3, 8'd7,  1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd0,  3'd7, 7'h00, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b01, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd5 },  // R5 wrap
        '{1'b1, 3'd4, 8'h0E, 1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h0E, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h0F, 4'd7 },  // R7 line 6->7
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 2'b01, 4'h0, 7'd0,  5'd0,  3'd0, 7'h10, 4'd7 },  // R7 next code
        '{1'b1, 3'd4, 8'h7F, 1'b0, 2'd0, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h7F, 4'd9 },
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 2'b00, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd7 },  // R7 code wrap
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd2, 2'b11, 4'h0, 7'd0,  5'd0,  3'd0, 7'h00, 4'd6 },  // R6
        '{1'b1, 3'd0, 8'h05, 1'b1, 2'd0, 2'b00, 4'h5, 7'd0,  5'd0,  3'd0, 7'h00, 4'd9 },  // R9 same target
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 2'b00, 4'h5, 7'd0,  5'd0,  3'd0, 7'h00, 4'd10},  // R10 target 3
        '{1'b1, 3'd7, 8'hFF, 1'b0, 2'd0, 2'b00, 4'h5, 7'd0,  5'd0,  3'd0, 7'h00, 4'd10},  // R10 code 7
        '{1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 2'b00, 4'h5, 7'd0,  5'd1,  3'd0, 7'h00, 4'd11},  // R11
        '{1'b1, 3'd1, 8'h03, 1'b1, 2'd1, 2'b00, 4'h5, 7'd3,  5'd2,  3'd0, 7'h00, 4'd9 }   // R9 other target
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_en, wr_en;
    logic [2:0] ld_reg;
    logic [7:0] ld_val, wr_data;
    logic [1:0] wr_tgt, inc_mode;
    logic [3:0] fd_x;
    logic [6:0] fd_y;
    logic [4:0] ch_x;
    logic [2:0] ch_y;
    logic [6:0] ug_addr;
    logic       ug_we;
    logic [4:0] ug_wdata;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dsp_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_reg(ld_reg), .ld_val(ld_val),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data), .inc_mode(inc_mode),
        .fd_x(fd_x), .fd_y(fd_y), .ch_x(ch_x), .ch_y(ch_y), .ug_addr(ug_addr),
        .ug_we(ug_we), .ug_wdata(ug_wdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 1'b0; wr_en = 1'b0; ld_reg = '0; ld_val = '0;
        wr_tgt = '0; wr_data = '0; inc_mode = '0;
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic l, input logic [2:0] lr, input logic [7:0] lv,
                        input logic w, input logic [1:0] t, input logic [1:0] m);
        ld_en = l; ld_reg = lr; ld_val = lv; wr_en = w; wr_tgt = t; inc_mode = m;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_P * 20000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", "fd_x", fd_x, 0);
        check("R1", "fd_y", fd_y, 0);
        check("R1", "ch_x", ch_x, 0);
        check("R1", "ch_y", ch_y, 0);
        check("R1", "ug_addr", ug_addr, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            step(VECS[i].ld, VECS[i].lreg, VECS[i].lval, VECS[i].wr, VECS[i].tgt, VECS[i].mode);
            check(tag, $sformatf("v%0d fd_x", i), fd_x, VECS[i].fx);
            check(tag, $sformatf("v%0d fd_y", i), fd_y, VECS[i].fy);
            check(tag, $sformatf("v%0d ch_x", i), ch_x, VECS[i].cx);
            check(tag, $sformatf("v%0d ch_y", i), ch_y, VECS[i].cy);
            check(tag, $sformatf("v%0d ug_addr", i), ug_addr, VECS[i].ug);
        end

        // R8: glyph write at line 6 is enabled and masked to 5 bits
        step(1'b1, 3'd4, 8'h06, 1'b0, 2'd0, 2'b00);
        wr_en = 1'b1; wr_tgt = 2'd2; inc_mode = 2'b00; wr_data = 8'hF3;
        #1;
        check("R8", "ug_we line6", ug_we, 1);
        check("R8", "ug_wdata", ug_wdata, 5'h13);
        @(posedge clk);
        @(negedge clk);
        idle();
        check("R7", "ug_addr after line6", ug_addr, 7'h07);
        // R8: spare line 7 write is suppressed
        wr_en = 1'b1; wr_tgt = 2'd2; wr_data = 8'hFF;
        #1;
        check("R8", "ug_we line7", ug_we, 0);
        @(posedge clk);
        @(negedge clk);
        idle();
        check("R7", "ug_addr after spare", ug_addr, 7'h08);
        // R8: non-glyph target never enables the glyph RAM
        wr_en = 1'b1; wr_tgt = 2'd0;
        #1;
        check("R8", "ug_we other target", ug_we, 0);
        @(negedge clk);
        idle();

        // R1: reset from a non-zero state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "fd_x after reset", fd_x, 0);
        check("R1", "fd_y after reset", fd_y, 0);
        check("R1", "ch_x after reset", ch_x, 0);
        check("R1", "ug_addr after reset", ug_addr, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule